// File: doc/BRIEF.md
# Out-of-Order Per-Bank Refresh Scheduler

This block sits inside a memory controller and decides when one rank receives per-bank refresh commands, and which bank each command targets. A periodic interval tick creates one refresh obligation for every bank. The scheduler keeps a signed debt counter per bank. A bank whose request queue is empty is refreshed while the other banks go on serving traffic. When the controller flushes a batch of buffered writes, banks that take no writes are refreshed early and build up credit. A bank that has put off its refresh for too long is refreshed whatever its queue holds.

At most one refresh is in flight at a time. The request strobe and its bank index hold steady until the command path accepts them. The accepted bank is then marked busy for a fixed number of cycles, which blocks demand accesses to that bank only.

Top module: `refresh_sched`

## Requirements
- R1: While reset is asserted and right after it, `ref_req` is 0, `bank_busy` is all zeros and every bank's debt is 0.
- R2: Each cycle with `ref_tick`=1 adds one to the debt of every bank, saturating at DEBT_MAX (8). Each accepted refresh lowers the target bank's debt by one. A tick and an accept in the same cycle cancel for the target bank.
- R3: When no bank is forced, the scheduler may target a bank with zero queue occupancy and debt above 0. Among such banks it picks the highest debt, and on a tie the lowest index.
- R4: Outside write drain, a bank with nonzero queue occupancy is never targeted while its debt is below DEBT_MAX.
- R5: A bank whose debt equals DEBT_MAX is forced: it wins over every other class regardless of its occupancy. Among forced banks the lowest index wins.
- R6: When `wr_drain`=1 and no forced or idle-owing bank exists, a bank with `wr_mask` bit 0 and debt above -CREDIT_LIM is refreshed early (highest debt, then lowest index). A bank with `wr_mask` bit 1 is never chosen this way.
- R7: Once raised, `ref_req` and `ref_bank` hold their values until a cycle with `ref_ack`=1. `ref_ack` while `ref_req`=0 has no effect.
- R8: After the cycle in which `ref_req` and `ref_ack` are both 1, `bank_busy` is one-hot on the accepted bank for exactly TRFC (12) cycles. Otherwise it is zero.
- R9: `ref_req` is never 1 while any `bank_busy` bit is set.
- R10: Early refreshes stop once a bank's debt reaches -CREDIT_LIM (-8). With no ticks, each eligible bank receives exactly CREDIT_LIM early refreshes after reset.
- R11: The choice is made in a cycle with no request pending and no bank busy, from that cycle's debts and inputs, and `ref_req` rises in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_occ | input | NBANK*OCC_W | Queue occupancy per bank, bank b in bits [b*OCC_W +: OCC_W] |
| wr_drain | input | 1 | Controller is flushing buffered writes |
| wr_mask | input | NBANK | Bit b set: bank b is receiving drain writes |
| ref_tick | input | 1 | Refresh interval tick, one cycle |
| ref_ack | input | 1 | Command path accepts the pending refresh |
| ref_req | output | 1 | Refresh request strobe |
| ref_bank | output | $clog2(NBANK) | Target bank of the request |
| bank_busy | output | NBANK | Banks under refresh, demand blocked |

## Verification
The bench goes after the priority order between forced, idle-owing and early banks, and after the lowest-index tie-break. A design that got either wrong would issue a refresh to a different bank than the model. Saturation of the debt counter is checked by piling up more ticks than the limit: a counter that wraps or keeps counting would refresh a bank too many times. The credit floor is checked by draining with no ticks until exactly CREDIT_LIM early refreshes per unwritten bank have gone out. A design without the floor keeps refreshing, and one that ignores the write mask hits written banks. A request held against a withheld accept, together with stray accepts, exposes a bank index that drifts or a request that drops on its own.

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int NBANK      = 8,
  parameter int OCC_W      = 6,
  parameter int TRFC       = 12,
  parameter int DEBT_MAX   = 8,
  parameter int CREDIT_LIM = 8,
  localparam int BW = $clog2(NBANK),
  localparam int DW = $clog2((DEBT_MAX > CREDIT_LIM) ? DEBT_MAX : CREDIT_LIM) + 2,
  localparam int CW = $clog2(TRFC + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NBANK*OCC_W-1:0] q_occ,
  input  logic                   wr_drain,
  input  logic [NBANK-1:0]       wr_mask,
  input  logic                   ref_tick,
  input  logic                   ref_ack,
  output logic                   ref_req,
  output logic [BW-1:0]          ref_bank,
  output logic [NBANK-1:0]       bank_busy
);
  localparam logic signed [DW-1:0] DMAX = DW'(DEBT_MAX);
  localparam logic signed [DW-1:0] DMIN = -(DW'(CREDIT_LIM));
  localparam logic signed [DW-1:0] ONE  = DW'(1);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_BUSY} state_t;
  state_t state;
  logic [CW-1:0] cnt;
  logic signed [DW-1:0] debt [NBANK];

  logic take;
  assign take = (state == S_REQ) && ref_ack;

  logic                 sel_valid;
  logic [BW-1:0]        sel_bank;
  logic [1:0]           best_cls;
  logic signed [DW-1:0] best_debt;
  logic [1:0]           cls;

  always_comb begin
    sel_valid = 1'b0;
    sel_bank  = '0;
    best_cls  = 2'd0;
    best_debt = '0;
    cls       = 2'd0;
    for (int b = 0; b < NBANK; b++) begin
      if (debt[b] >= DMAX)
        cls = 2'd3;
      else if (q_occ[b*OCC_W +: OCC_W] == '0 && debt[b] > '0)
        cls = 2'd2;
      else if (wr_drain && !wr_mask[b] && debt[b] > DMIN)
        cls = 2'd1;
      else
        cls = 2'd0;
      if (cls != 2'd0 && (!sel_valid || cls > best_cls ||
                          (cls == best_cls && debt[b] > best_debt))) begin
        sel_valid = 1'b1;
        sel_bank  = BW'(b);
        best_cls  = cls;
        best_debt = debt[b];
      end
    end
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_debt
    logic inc, dec;
    assign inc = ref_tick && (debt[g] != DMAX);
    assign dec = take && (ref_bank == BW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)
        debt[g] <= '0;
      else if (inc && !dec)
        debt[g] <= debt[g] + ONE;
      else if (dec && !inc)
        debt[g] <= debt[g] - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      ref_bank <= '0;
      cnt      <= '0;
    end else begin
      case (state)
        S_IDLE:
          if (sel_valid) begin
            state    <= S_REQ;
            ref_bank <= sel_bank;
          end
        S_REQ:
          if (ref_ack) begin
            state <= S_BUSY;
            cnt   <= CW'(TRFC - 1);
          end
        default:
          if (cnt == '0) state <= S_IDLE;
          else           cnt   <= cnt - 1'b1;
      endcase
    end
  end

  assign ref_req   = (state == S_REQ);
  assign bank_busy = (state == S_BUSY) ? (NBANK'(1) << ref_bank) : '0;
endmodule

module refresh_sched_chk #(
  parameter int NBANK = 8,
  parameter int TRFC  = 12,
  localparam int BW = $clog2(NBANK),
  localparam int LW = $clog2(TRFC + 2) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_req,
  input logic             ref_ack,
  input logic [BW-1:0]    ref_bank,
  input logic [NBANK-1:0] bank_busy
);
  logic [LW-1:0] busy_len;
  always_ff @(posedge clk) begin
    if (!rst_n || bank_busy == '0) busy_len <= '0;
    else                           busy_len <= busy_len + 1'b1;
  end

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req && !ref_ack |=> ref_req && $stable(ref_bank));
  // R8
  busy_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_busy));
  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req && ref_ack |=> bank_busy == (NBANK'(1) << $past(ref_bank)));
  // R8
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|bank_busy) |-> busy_len == LW'(TRFC));
  // R9
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ref_req && (bank_busy != '0)));
  // R11
  gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|bank_busy) |-> !ref_req);
endmodule

bind refresh_sched refresh_sched_chk #(.NBANK(NBANK), .TRFC(TRFC)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .ref_ack(ref_ack),
  .ref_bank(ref_bank), .bank_busy(bank_busy)
);

// File: tb/refresh_sched_bench.sv
module refresh_sched_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 8, OW = 6, TRFC = 12, DMAXV = 8, LIM = 8;
  localparam int BW = $clog2(NB);

  logic clk = 0, rst_n = 0;
  logic [NB*OW-1:0] q_occ = '0;
  logic wr_drain = 0, ref_tick = 0, ref_ack = 0;
  logic [NB-1:0] wr_mask = '0;
  logic ref_req;
  logic [BW-1:0] ref_bank;
  logic [NB-1:0] bank_busy;

  refresh_sched #(.NBANK(NB), .OCC_W(OW), .TRFC(TRFC), .DEBT_MAX(DMAXV),
                  .CREDIT_LIM(LIM)) u_refresh_sched (
    .clk(clk), .rst_n(rst_n), .q_occ(q_occ), .wr_drain(wr_drain),
    .wr_mask(wr_mask), .ref_tick(ref_tick), .ref_ack(ref_ack),
    .ref_req(ref_req), .ref_bank(ref_bank), .bank_busy(bank_busy));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0, n_fail = 0;
  int m_debt [NB];
  int m_state, m_bank, m_cnt;
  int issued [NB];
  bit m_rst;

  function automatic int occ_of(int b);
    return int'(q_occ[b*OW +: OW]);
  endfunction

  function automatic int pick();
    int best = -1, bc = 0, bd = 0;
    for (int b = 0; b < NB; b++) begin
      int c;
      if (m_debt[b] >= DMAXV) c = 3;
      else if (occ_of(b) == 0 && m_debt[b] > 0) c = 2;
      else if (wr_drain && !wr_mask[b] && m_debt[b] > -LIM) c = 1;
      else c = 0;
      if (c != 0 && (best < 0 || c > bc || (c == bc && m_debt[b] > bd))) begin
        best = b; bc = c; bd = m_debt[b];
      end
    end
    return best;
  endfunction

  task automatic model_reset();
    for (int b = 0; b < NB; b++) begin m_debt[b] = 0; issued[b] = 0; end
    m_state = 0; m_bank = 0; m_cnt = 0;
  endtask

  task automatic model_next();
    int p;
    bit take;
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) m_debt[b] = 0;
      m_state = 0; m_bank = 0; m_cnt = 0;
      return;
    end
    p = pick();
    take = (m_state == 1) && ref_ack;
    if (take) issued[m_bank]++;
    for (int b = 0; b < NB; b++) begin
      int inc, dec;
      inc = (ref_tick && m_debt[b] < DMAXV) ? 1 : 0;
      dec = (take && m_bank == b) ? 1 : 0;
      m_debt[b] = m_debt[b] + inc - dec;
    end
    case (m_state)
      0: if (p >= 0) begin m_state = 1; m_bank = p; end
      1: if (ref_ack) begin m_state = 2; m_cnt = TRFC - 1; end
      default: if (m_cnt == 0) m_state = 0; else m_cnt--;
    endcase
  endtask

  task automatic check(string tag, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    int eb;
    eb = (m_state == 2) ? (1 << m_bank) : 0;
    check(tag, "ref_req", int'(ref_req), (m_state == 1) ? 1 : 0);
    if (m_state == 1) check(tag, "ref_bank", int'(ref_bank), m_bank);
    check("R8", "bank_busy", int'(bank_busy), eb);
    if (bank_busy != '0) check("R9", "req_during_busy", int'(ref_req), 0);
  endtask

  task automatic step(string tag);
    model_next();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset();
    rst_n = 0; q_occ = '0; wr_drain = 0; wr_mask = '0; ref_tick = 0; ref_ack = 0;
    model_reset();
    repeat (2) step("R1");
    rst_n = 1;
    for (int b = 0; b < NB; b++) issued[b] = 0;
  endtask

  task automatic set_occ_all(int v);
    for (int b = 0; b < NB; b++) q_occ[b*OW +: OW] = OW'(v);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int tot;
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset();
    check("R1", "busy_after_reset", int'(bank_busy), 0);
    check("R1", "req_after_reset", int'(ref_req), 0);

    // R3: all idle, two ticks, tie-break by lowest index
    ref_tick = 1; step("R3"); step("R3"); ref_tick = 0;
    for (int i = 0; i < 300; i++) begin ref_ack = ref_req; step("R3"); end
    for (int b = 0; b < NB; b++) check("R3", "idle_refresh_count", issued[b], 2);

    // R4: banks 0..3 busy with requests, only 4..7 refreshed
    do_reset();
    for (int b = 0; b < 4; b++) q_occ[b*OW +: OW] = OW'(3);
    for (int i = 0; i < 3; i++) begin ref_tick = 1; step("R4"); ref_tick = 0; step("R4"); end
    for (int i = 0; i < 250; i++) begin ref_ack = ref_req; step("R4"); end
    tot = 0;
    for (int b = 0; b < 4; b++) tot += issued[b];
    check("R4", "pending_bank_refreshes", tot, 0);

    // R7/R2/R5: all queues busy, ticks past the limit, accept withheld
    do_reset();
    set_occ_all(5);
    for (int i = 0; i < 12; i++) begin ref_tick = 1; ref_ack = 0; step("R7"); end
    ref_tick = 0;
    for (int i = 0; i < 6; i++) step("R7");
    check("R5", "forced_bank_first", int'(ref_bank), 0);
    for (int i = 0; i < 250; i++) begin ref_ack = ref_req; step("R5"); end
    tot = 0;
    for (int b = 0; b < NB; b++) tot += issued[b];
    check("R2", "saturated_forced_count", tot, NB);

    // R6/R10: drain with banks 0..3 written, no ticks
    do_reset();
    set_occ_all(2);
    wr_drain = 1; wr_mask = 8'h0F;
    for (int i = 0; i < 700; i++) begin ref_ack = ref_req; step("R6"); end
    tot = 0;
    for (int b = 0; b < 4; b++) tot += issued[b];
    check("R6", "written_bank_refreshes", tot, 0);
    tot = 0;
    for (int b = 4; b < NB; b++) tot += issued[b];
    check("R10", "early_refresh_total", tot, 4 * LIM);
    check("R10", "req_after_floor", int'(ref_req), 0);

    // R11: random traffic with stray accepts
    do_reset();
    for (int i = 0; i < 6000; i++) begin
      for (int b = 0; b < NB; b++)
        q_occ[b*OW +: OW] = ($urandom_range(1, 0) == 0) ? '0 : OW'($urandom_range(9, 1));
      wr_drain = ($urandom_range(9, 0) < 3);
      wr_mask  = NB'($urandom);
      ref_tick = ($urandom_range(15, 0) == 0);
      ref_ack  = ($urandom_range(1, 0) == 1);
      step("R11");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule